// File: doc/BRIEF.md
# Senior Store Queue with Load Forwarding

This block is a circular queue of stores. Stores stay in place after they commit until their cache write has finished, so no separate writeback buffer is needed. Three pointers divide the ring. The tail is where the next store is allocated. The commit pointer separates the older, committed ("senior") stores from the younger, speculative ones. The head is the oldest senior store whose cache write is still outstanding. Commit never waits for the cache: it only moves the commit pointer. A small drain state machine then sends senior stores to the cache one at a time, in order, over a valid/ready port.

A load searches the queue with its own queue position, which is the tail value at the time the load was dispatched, and with its word address. It gets the data of the youngest older store that has a valid, matching address. If that store's data is not yet present, the load gets a stall flag instead. Senior stores keep forwarding until they drain. A flush throws away every speculative store and leaves the senior stores untouched.

The drain machine has two states. DR_IDLE moves to DR_WRITE when the senior region is not empty. DR_WRITE stays in DR_WRITE while a write waits for the cache or another senior store remains. DR_WRITE returns to DR_IDLE when a handshake takes the last senior store and no commit arrives in the same cycle.

Top module: `senior_store_queue`

## Requirements
- R1: After reset the queue is empty: `alloc_ready_o`=1, `alloc_pos_o`=0, `wr_valid_o`=0, `ld_hit_o`=0 and `ld_stall_o`=0.
- R2: A queue position is 5 bits: bit 4 is a wrap flag and bits 3:0 are the slot. `alloc_pos_o` shows the tail position. When `alloc_valid_i` is high, `alloc_ready_o` is high and `flush_i` is low, the tail advances by one. With 16 entries occupied, `alloc_ready_o` is 0 and a request has no effect.
- R3: In a cycle with `exec_addr_en_i` high, the address of slot `exec_idx_i` is written and marked valid. In a cycle with `exec_data_en_i` high, the data of that slot is written and marked valid. A fresh allocation clears both marks.
- R4: With `commit_valid_i` high and at least one speculative entry, the commit pointer advances by one, whatever the state of the cache port. While senior entries exist, `wr_valid_o` is low for at most one cycle in a row. The writes present the senior entries in commit order, starting at the head.
- R5: Once `wr_valid_o` is high, it and `wr_addr_o`/`wr_data_o` hold steady until `wr_ready_i` is high. Each handshake frees exactly one entry by advancing the head.
- R6: Senior entries still count as occupied. A queue holding 16 committed but undrained stores refuses allocation until a handshake frees a slot.
- R7: `flush_i` sets the tail to the commit pointer, taking into account a commit in the same cycle. An allocation request in a flush cycle is ignored. Senior entries survive and still drain.
- R8: A load takes the data of the youngest store that lies between the head and `ld_pos_i` (exclusive), has a valid address and has an address equal to `ld_addr_i`. It then sees `ld_hit_o`=1 and that data on `ld_data_o`.
- R9: If that youngest match has no valid data, `ld_stall_o`=1 and `ld_hit_o`=0; an older match is not used instead.
- R10: Senior entries forward to loads until their cache write handshake completes.
- R11: Stores at or after `ld_pos_i`, stores already drained, and stores without a valid address never match; with no match, hit and stall are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid_i | input | 1 | Allocation request |
| alloc_ready_o | output | 1 | Queue has a free slot |
| alloc_pos_o | output | 5 | Position of the next allocation (wrap flag + slot) |
| exec_addr_en_i | input | 1 | Write store address |
| exec_data_en_i | input | 1 | Write store data |
| exec_idx_i | input | 4 | Slot being executed |
| exec_addr_i | input | 16 | Store word address |
| exec_data_i | input | 32 | Store data |
| commit_valid_i | input | 1 | Commit the oldest speculative store |
| flush_i | input | 1 | Discard all speculative stores |
| wr_valid_o | output | 1 | Cache write request |
| wr_ready_i | input | 1 | Cache accepts the write |
| wr_addr_o | output | 16 | Cache write address |
| wr_data_o | output | 32 | Cache write data |
| ld_pos_i | input | 5 | Load's queue position |
| ld_addr_i | input | 16 | Load word address |
| ld_hit_o | output | 1 | Forwarded data valid |
| ld_data_o | output | 32 | Forwarded data |
| ld_stall_o | output | 1 | Matching store has no data yet |

## Verification
Several functions can fall in the same cycle. A commit can meet a cache handshake, a flush can meet both a commit and an allocation request, and a load search can hit a senior entry in the very cycle that entry drains. A random mix, with the cache ready line toggled at random, produces these overlaps in great numbers. Directed sequences force commit-with-flush, allocation-with-flush and the full-of-senior-entries case. A bench model of the pointers and entries predicts the allocation position, the store at the cache port and the forwarding result every cycle. The DUT's outputs are compared against it just before each clock edge.

// File: rtl/sq_pkg.sv
package sq_pkg;
    typedef enum logic [0:0] {
        DR_IDLE  = 1'b0,
        DR_WRITE = 1'b1
    } drain_state_t;
endpackage

// File: rtl/sq_ptr_ctrl.sv
module sq_ptr_ctrl #(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             do_alloc,
    input  logic             do_commit,
    input  logic             do_drain,
    input  logic             flush,
    output logic [PTR_W-1:0] head_q,
    output logic [PTR_W-1:0] cmt_q,
    output logic [PTR_W-1:0] tail_q,
    output logic [PTR_W-1:0] occ,
    output logic [PTR_W-1:0] senior
);
    logic [PTR_W-1:0] cmt_d;

    assign occ    = tail_q - head_q;
    assign senior = cmt_q - head_q;
    assign cmt_d  = cmt_q + PTR_W'(do_commit);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            cmt_q  <= '0;
            tail_q <= '0;
        end else begin
            head_q <= head_q + PTR_W'(do_drain);
            cmt_q  <= cmt_d;
            tail_q <= flush ? cmt_d : tail_q + PTR_W'(do_alloc);
        end
    end
endmodule

// File: rtl/sq_entry_array.sv
module sq_entry_array #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              do_alloc,
    input  logic [IDX_W-1:0]  alloc_slot,
    input  logic              addr_en,
    input  logic              data_en,
    input  logic [IDX_W-1:0]  exec_slot,
    input  logic [ADDR_W-1:0] exec_addr,
    input  logic [DATA_W-1:0] exec_data,
    output logic [DEPTH-1:0]  addr_ok,
    output logic [DEPTH-1:0]  data_ok,
    output logic [ADDR_W-1:0] addr_q [DEPTH],
    output logic [DATA_W-1:0] data_q [DEPTH]
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                addr_ok[g] <= 1'b0;
                data_ok[g] <= 1'b0;
                addr_q[g]  <= '0;
                data_q[g]  <= '0;
            end else begin
                if (do_alloc && alloc_slot == IDX_W'(g)) begin
                    addr_ok[g] <= 1'b0;
                    data_ok[g] <= 1'b0;
                end
                if (addr_en && exec_slot == IDX_W'(g)) begin
                    addr_ok[g] <= 1'b1;
                    addr_q[g]  <= exec_addr;
                end
                if (data_en && exec_slot == IDX_W'(g)) begin
                    data_ok[g] <= 1'b1;
                    data_q[g]  <= exec_data;
                end
            end
        end
    end
endmodule

// File: rtl/sq_fwd_search.sv
module sq_fwd_search #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1
) (
    input  logic [PTR_W-1:0]  head,
    input  logic [PTR_W-1:0]  occ,
    input  logic [PTR_W-1:0]  ld_pos,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DEPTH-1:0]  addr_ok,
    input  logic [DEPTH-1:0]  data_ok,
    input  logic [ADDR_W-1:0] addr_q [DEPTH],
    input  logic [DATA_W-1:0] data_q [DEPTH],
    output logic              hit,
    output logic              stall,
    output logic [DATA_W-1:0] data
);
    logic [PTR_W-1:0] lim;
    logic [PTR_W-1:0] raw;
    logic [PTR_W-1:0] off;
    logic [PTR_W-1:0] best;
    logic [IDX_W-1:0] sel;
    logic             found;

    always_comb begin
        raw   = ld_pos - head;
        lim   = (raw > occ) ? occ : raw;
        found = 1'b0;
        best  = '0;
        sel   = '0;
        off   = '0;
        for (int j = 0; j < DEPTH; j++) begin
            off = {1'b0, IDX_W'(j) - head[IDX_W-1:0]};
            if (off < lim && addr_ok[j] && addr_q[j] == ld_addr &&
                (!found || off > best)) begin
                found = 1'b1;
                best  = off;
                sel   = IDX_W'(j);
            end
        end
        hit   = found && data_ok[sel];
        stall = found && !data_ok[sel];
        data  = hit ? data_q[sel] : '0;
    end
endmodule

// File: rtl/sq_drain_fsm.sv
module sq_drain_fsm #(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PTR_W-1:0] senior,
    input  logic             do_commit,
    input  logic             wr_ready,
    output logic             wr_valid
);
    import sq_pkg::*;

    drain_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DR_IDLE:  if (senior != '0) state_d = DR_WRITE;
            DR_WRITE: if (wr_ready && senior == PTR_W'(1) && !do_commit)
                          state_d = DR_IDLE;
            default:  state_d = DR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= DR_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        wr_valid = (state_q == DR_WRITE);
    end
endmodule

// File: rtl/senior_store_queue.sv
module senior_store_queue #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid_i,
    output logic              alloc_ready_o,
    output logic [PTR_W-1:0]  alloc_pos_o,
    input  logic              exec_addr_en_i,
    input  logic              exec_data_en_i,
    input  logic [IDX_W-1:0]  exec_idx_i,
    input  logic [ADDR_W-1:0] exec_addr_i,
    input  logic [DATA_W-1:0] exec_data_i,
    input  logic              commit_valid_i,
    input  logic              flush_i,
    output logic              wr_valid_o,
    input  logic              wr_ready_i,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    input  logic [PTR_W-1:0]  ld_pos_i,
    input  logic [ADDR_W-1:0] ld_addr_i,
    output logic              ld_hit_o,
    output logic [DATA_W-1:0] ld_data_o,
    output logic              ld_stall_o
);
    logic [PTR_W-1:0]  head_q, cmt_q, tail_q, occ, senior;
    logic              do_alloc, do_commit, do_drain;
    logic [DEPTH-1:0]  addr_ok, data_ok;
    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];

    assign alloc_ready_o = (occ != PTR_W'(DEPTH));
    assign alloc_pos_o   = tail_q;
    assign do_alloc      = alloc_valid_i && alloc_ready_o && !flush_i;
    assign do_commit     = commit_valid_i && (cmt_q != tail_q);
    assign do_drain      = wr_valid_o && wr_ready_i;
    assign wr_addr_o     = addr_q[head_q[IDX_W-1:0]];
    assign wr_data_o     = data_q[head_q[IDX_W-1:0]];

    sq_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
        .clk(clk), .rst_n(rst_n), .do_alloc(do_alloc), .do_commit(do_commit),
        .do_drain(do_drain), .flush(flush_i), .head_q(head_q), .cmt_q(cmt_q),
        .tail_q(tail_q), .occ(occ), .senior(senior)
    );

    sq_entry_array #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
        .clk(clk), .rst_n(rst_n), .do_alloc(do_alloc),
        .alloc_slot(tail_q[IDX_W-1:0]), .addr_en(exec_addr_en_i),
        .data_en(exec_data_en_i), .exec_slot(exec_idx_i),
        .exec_addr(exec_addr_i), .exec_data(exec_data_i),
        .addr_ok(addr_ok), .data_ok(data_ok), .addr_q(addr_q), .data_q(data_q)
    );

    sq_fwd_search #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fwd (
        .head(head_q), .occ(occ), .ld_pos(ld_pos_i), .ld_addr(ld_addr_i),
        .addr_ok(addr_ok), .data_ok(data_ok), .addr_q(addr_q), .data_q(data_q),
        .hit(ld_hit_o), .stall(ld_stall_o), .data(ld_data_o)
    );

    sq_drain_fsm #(.DEPTH(DEPTH)) u_drain (
        .clk(clk), .rst_n(rst_n), .senior(senior), .do_commit(do_commit),
        .wr_ready(wr_ready_i), .wr_valid(wr_valid_o)
    );
endmodule

// File: rtl/sq_checker.sv
module sq_checker #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    localparam int PTR_W = $clog2(DEPTH) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              alloc_ready_o,
    input logic              flush_i,
    input logic              wr_valid_o,
    input logic              wr_ready_i,
    input logic [ADDR_W-1:0] wr_addr_o,
    input logic [DATA_W-1:0] wr_data_o,
    input logic [PTR_W-1:0]  head_q,
    input logic [PTR_W-1:0]  cmt_q,
    input logic [PTR_W-1:0]  tail_q
);
    logic [PTR_W-1:0] used, sen;
    assign used = tail_q - head_q;
    assign sen  = cmt_q - head_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        used <= PTR_W'(DEPTH)); // R2
    AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
        used == PTR_W'(DEPTH) |-> !alloc_ready_o); // R6
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o)); // R5
    AST_HEAD_ONLY_ON_HS: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_valid_o && wr_ready_i) |=> $stable(head_q)); // R5
    AST_FLUSH_TO_CMT: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> tail_q == cmt_q); // R7
    AST_SENIOR_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        sen <= used); // R7
    AST_VALID_WHEN_SENIOR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o |-> sen != '0); // R4
endmodule

bind senior_store_queue sq_checker #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .alloc_ready_o(alloc_ready_o), .flush_i(flush_i),
    .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i), .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o), .head_q(head_q), .cmt_q(cmt_q), .tail_q(tail_q)
);

// File: tb/senior_store_queue_tb.sv
module senior_store_queue_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_valid_i = 0, exec_addr_en_i = 0, exec_data_en_i = 0;
    logic [3:0]  exec_idx_i = '0;
    logic [15:0] exec_addr_i = '0, ld_addr_i = '0;
    logic [31:0] exec_data_i = '0;
    logic        commit_valid_i = 0, flush_i = 0, wr_ready_i = 0;
    logic [4:0]  ld_pos_i = '0;
    logic        alloc_ready_o, wr_valid_o, ld_hit_o, ld_stall_o;
    logic [4:0]  alloc_pos_o;
    logic [15:0] wr_addr_o;
    logic [31:0] wr_data_o, ld_data_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    senior_store_queue dut_i (.*);

    int n_chk = 0, n_bad = 0, idle_run = 0;
    bit done = 0;
    int mh = 0, mc = 0, mt = 0;
    bit m_av [N];
    bit m_dv [N];
    int m_addr [N];
    int m_data [N];

    task automatic chk(bit ok, string req, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int cnt(); return (mt - mh + 32) % 32; endfunction
    function automatic int sen(); return (mc - mh + 32) % 32; endfunction

    // expected load result: {stall, hit, data}
    task automatic ld_model(int lpos, int laddr, output bit h, output bit s, output int d);
        int lim = (lpos - mh + 32) % 32;
        int best = -1;
        if (lim > cnt()) lim = cnt();
        for (int k = 0; k < lim; k++) begin
            int sl = (mh + k) % N;
            if (m_av[sl] && m_addr[sl] == laddr) best = sl;
        end
        h = (best >= 0) && m_dv[best];
        s = (best >= 0) && !m_dv[best];
        d = h ? m_data[best] : 0;
    endtask

    task automatic step(bit av, bit ea, bit ed, int eidx, int ead, int edt,
                        bit cm, bit fl, bit rdy, int lpos, int lad, string tag);
        bit eh, es, hs; int edat;
        @(negedge clk);
        alloc_valid_i = av; exec_addr_en_i = ea; exec_data_en_i = ed;
        exec_idx_i = 4'(eidx); exec_addr_i = 16'(ead); exec_data_i = edt;
        commit_valid_i = cm; flush_i = fl; wr_ready_i = rdy;
        ld_pos_i = 5'(lpos); ld_addr_i = 16'(lad);
        #1;
        chk(alloc_ready_o == (cnt() < N), {"R2 R6 alloc_ready ", tag}, alloc_ready_o, cnt() < N);
        chk(alloc_pos_o == 5'(mt), {"R2 alloc_pos ", tag}, alloc_pos_o, mt);
        if (wr_valid_o) begin
            chk(sen() > 0, {"R4 wr_valid with no senior ", tag}, sen(), 1);
            chk(wr_addr_o == 16'(m_addr[mh % N]), {"R4 R5 wr_addr ", tag}, wr_addr_o, m_addr[mh % N]);
            chk(wr_data_o == m_data[mh % N], {"R4 R5 wr_data ", tag}, wr_data_o, m_data[mh % N]);
            idle_run = 0;
        end else if (sen() > 0) begin
            idle_run++;
            chk(idle_run <= 1, {"R4 drain idle too long ", tag}, idle_run, 1);
        end else idle_run = 0;
        ld_model(lpos, lad, eh, es, edat);
        chk(ld_hit_o == eh && ld_stall_o == es, {"R8 R9 R11 ld flags ", tag},
            {ld_stall_o, ld_hit_o}, {es, eh});
        chk(ld_data_o == edat, {"R3 R8 R10 ld data ", tag}, ld_data_o, edat);
        hs = wr_valid_o && rdy;
        @(posedge clk);
        if (av && cnt() < N && !fl) begin
            m_av[mt % N] = 0; m_dv[mt % N] = 0; mt = (mt + 1) % 32;
        end
        if (ea) begin m_av[eidx] = 1; m_addr[eidx] = ead & 16'hffff; end
        if (ed) begin m_dv[eidx] = 1; m_data[eidx] = edt; end
        if (cm && mc != mt) mc = (mc + 1) % 32;
        if (hs) mh = (mh + 1) % 32;
        if (fl) mt = mc;
    endtask

    task automatic idle_step(bit rdy, int lpos, int lad, string tag);
        step(0, 0, 0, 0, 0, 0, 0, 0, rdy, lpos, lad, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5e5_0417));
        for (int i = 0; i < N; i++) begin m_av[i] = 0; m_dv[i] = 0; m_addr[i] = 0; m_data[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        #1;
        chk(alloc_ready_o == 1 && alloc_pos_o == 0, "R1 reset alloc", {alloc_ready_o, alloc_pos_o}, 6'h20);
        chk(wr_valid_o == 0 && ld_hit_o == 0 && ld_stall_o == 0, "R1 reset outputs",
            {wr_valid_o, ld_hit_o, ld_stall_o}, 0);

        // fill all 16, execute, commit with cache stalled: seniors block allocation (R6)
        for (int i = 0; i < N; i++) step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "fill");
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 full ignored");
        for (int i = 0; i < N; i++) step(0, 1, 1, i, 16'h40 + (i % 4), 32'hA000 + i, 0, 0, 0, 16, 16'h41, "exec");
        for (int i = 0; i < N; i++) step(0, 0, 0, 0, 0, 0, 1, 0, 0, 16, 16'h42, "commit");
        // R10: senior entries forward; youngest older match is slot 14
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, 16, 16'h42, "R6 R10 all senior");
        chk(ld_data_o == 32'hA00E, "R10 senior forward youngest", ld_data_o, 32'hA00E);
        step(0, 0, 0, 0, 0, 0, 0, 1, 0, 16, 16'h43, "R7 flush keeps seniors");
        for (int i = 0; i < 6; i++) idle_step(1, 16, 16'h40, "R4 drain");
        // commit + flush + alloc same cycle (R7)
        step(1, 0, 0, 0, 0, 0, 0, 0, 1, mh, 0, "alloc");
        step(1, 0, 0, 0, 0, 0, 0, 0, 1, mh, 0, "alloc");
        step(0, 1, 1, mc % N, 16'h77, 32'h1234, 0, 0, 1, mh, 0, "exec");
        step(1, 0, 0, 0, 0, 0, 1, 1, 1, mh, 0, "R7 commit flush alloc");
        // R9: address-only store stalls load, older data store not used
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, mh, 0, "alloc");
        step(0, 1, 1, (mt + 31) % 32 % N, 16'h90, 32'hBEEF, 0, 0, 0, mh, 0, "exec");
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, mh, 0, "alloc");
        step(0, 1, 0, (mt + 31) % 32 % N, 16'h90, 0, 0, 0, 0, mt, 16'h90, "exec addr only");
        idle_step(0, mt, 16'h90, "R9 stall");
        chk(ld_stall_o == 1 && ld_hit_o == 0, "R9 stall on youngest", {ld_stall_o, ld_hit_o}, 2'b10);
        idle_step(0, (mt + 31) % 32, 16'h90, "R11 pos excludes");

        // constrained random mix
        for (int c = 0; c < 4000; c++) begin
            int s = (mt - mc + 32) % 32;
            int r = (s > 0) ? (mc + $urandom_range(0, s - 1)) % 32 : 0;
            bit e = (s > 0) && ($urandom_range(0, 2) != 0);
            bit cm = (mc != mt) && m_av[mc % N] && m_dv[mc % N] && ($urandom_range(0, 2) == 0);
            int lp = (mh + $urandom_range(0, cnt())) % 32;
            step($urandom_range(0, 1), e && $urandom_range(0, 1), e && $urandom_range(0, 1),
                 r % N, $urandom_range(0, 7), $urandom, cm, $urandom_range(0, 24) == 0,
                 $urandom_range(0, 3) != 0, lp, $urandom_range(0, 7), "rand");
        end
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule